// File: doc/BRIEF.md
# Shared Buffer Pool Channel Scheduler

This block decides which DMA logical channel may start its next source burst when all channels share one buffer pool placed between a read port and a write port. Channels wait in a round-robin queue. Each cycle the scheduler walks the queue from its head and grants the first requesting channel whose burst the pool can take now and that is still under the global per-channel entry limit. A granted burst reserves its words in the pool at once. Each word that leaves on the write side returns one entry to the pool.

A channel that stands ahead of the winner but was passed over only because the pool lacked room for its burst moves to the tail of the queue, so a large burst cannot hold up smaller ones. The limit is tested against what a channel already holds, not against what it would hold after the burst. A channel at limit minus one can therefore be admitted and end up holding up to the limit plus its burst minus one. Address generation and the data path are outside this block.

Top module: `fpool_sched`

## Requirements
- R1: During and after a synchronous active-low reset, `grant_valid_o` is 0, every channel count on `alloc_o` is 0, `free_o` equals POOL_DEPTH, and the queue order from head to tail is channel 0, 1, ..., NCH-1.
- R2: A channel is eligible when its request bit is 1, its burst is nonzero, its count is below `limit_i`, and `free_o` is at least its burst. At the clock edge after an eligible channel is picked, `grant_valid_o` is 1, `grant_ch_o` names it, its count rises by its burst and `free_o` falls by the same amount.
- R3: The grant goes to the first eligible channel in queue order, and the granted channel moves to the tail of the queue.
- R4: Requesting channels below the limit that stand ahead of the granted one and lack pool room for their burst also move to the tail, keeping their relative order, placed before the granted channel.
- R5: In a cycle with no eligible channel, `grant_valid_o` is 0 at the next edge, the queue order does not change, and the counts change only through drains.
- R6: A channel whose count is below the limit is granted even if its burst takes it past the limit, so its count can reach limit + burst - 1. A channel at or above the limit is not granted and keeps its queue place.
- R7: A drain (`drain_valid_i` = 1) lowers the count of `drain_ch_i` by one and raises `free_o` by one at the next edge. A drain on a channel whose count is 0 has no effect.
- R8: A grant and a drain on the same channel in the same cycle change its count by burst - 1 and `free_o` by 1 - burst.
- R9: `free_o` plus the sum of all channel counts always equals POOL_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NCH | One request bit per channel |
| burst_i | input | NCH*CNT_W | Maximum source burst per channel in words, channel c at bits [c*CNT_W +: CNT_W] |
| limit_i | input | CNT_W | Global per-channel entry limit |
| drain_valid_i | input | 1 | One word was written out this cycle |
| drain_ch_i | input | CH_W | Channel whose word was written out |
| grant_valid_o | output | 1 | A grant was issued at the last edge |
| grant_ch_o | output | CH_W | Channel granted at the last edge |
| alloc_o | output | NCH*CNT_W | Pool entries held per channel, same packing as `burst_i` |
| free_o | output | CNT_W | Free pool entries |

## Verification
A grant and a drain can land on the same channel's count in the same cycle. The bench provokes this by granting a channel once, then holding its request while draining one of its words in the same cycle. It judges the outcome by the count rising by exactly burst minus one and the free count falling by the same amount. The same-cycle pairing of a pool-short requeue with a grant to a later channel is judged indirectly: after enough entries are drained to make the skipped channel fit, a third channel that now stands ahead of it must win.

// File: rtl/fpool_pkg.sv
// Shared sizing helpers for the buffer pool scheduler.
// Assumes: all widths derive from pool depth and channel count.
package fpool_pkg;

    // Bits needed to hold a count from 0 to n inclusive.
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

    // Bits needed to name one of n channels (at least one bit).
    function automatic int id_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fpool_queue.sv
// Round-robin channel queue. Picks the first eligible channel in queue order.
// On a grant, pool-short channels ahead of the winner and then the winner
// move to the tail; all other channels keep their relative order.
// Assumes: elig_i and short_i are never both set for one channel.
module fpool_queue #(
    parameter int NCH = 4,
    localparam int CH_W = fpool_pkg::id_bits(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  elig_i,
    input  logic [NCH-1:0]  short_i,
    output logic            pick_valid_o,
    output logic [CH_W-1:0] pick_ch_o
);

    logic [CH_W-1:0] order_q [NCH];
    logic [CH_W-1:0] order_d [NCH];
    logic [NCH-1:0]  moved;
    logic            found;
    logic [CH_W-1:0] win_pos;
    logic [CH_W:0]   slot;

    // Find the winner, mark the entries that go to the tail, build the new order.
    always_comb begin
        found   = 1'b0;
        win_pos = '0;
        for (int p = 0; p < NCH; p++) begin
            if (!found && elig_i[order_q[p]]) begin
                found   = 1'b1;
                win_pos = CH_W'(p);
            end
        end
        for (int p = 0; p < NCH; p++) begin
            moved[p] = found && ((CH_W'(p) == win_pos) ||
                                 ((CH_W'(p) < win_pos) && short_i[order_q[p]]));
        end
        for (int p = 0; p < NCH; p++) begin
            order_d[p] = order_q[p];
        end
        slot = '0;
        for (int p = 0; p < NCH; p++) begin
            if (!moved[p]) begin
                order_d[slot[CH_W-1:0]] = order_q[p];
                slot = slot + 1'b1;
            end
        end
        for (int p = 0; p < NCH; p++) begin
            if (moved[p] && (CH_W'(p) != win_pos)) begin
                order_d[slot[CH_W-1:0]] = order_q[p];
                slot = slot + 1'b1;
            end
        end
        if (found) begin
            order_d[slot[CH_W-1:0]] = order_q[win_pos];
        end
    end

    assign pick_valid_o = found;
    assign pick_ch_o    = order_q[win_pos];

    // Hold the queue order; reset to ascending channel numbers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                order_q[c] <= CH_W'(c);
            end
        end else if (found) begin
            for (int c = 0; c < NCH; c++) begin
                order_q[c] <= order_d[c];
            end
        end
    end

endmodule

// File: rtl/fpool_ledger.sv
// Per-channel entry counts and the free-entry count of the pool.
// A grant reserves its burst; each drained word returns one entry.
// Assumes: add_amt_i never exceeds the current free count.
module fpool_ledger #(
    parameter int NCH        = 4,
    parameter int POOL_DEPTH = 256,
    localparam int CNT_W = fpool_pkg::cnt_bits(POOL_DEPTH),
    localparam int CH_W  = fpool_pkg::id_bits(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 add_valid_i,
    input  logic [CH_W-1:0]      add_ch_i,
    input  logic [CNT_W-1:0]     add_amt_i,
    input  logic                 drain_valid_i,
    input  logic [CH_W-1:0]      drain_ch_i,
    output logic [NCH*CNT_W-1:0] alloc_o,
    output logic [CNT_W-1:0]     free_o
);

    logic [CNT_W-1:0] cnt_q [NCH];
    logic [NCH-1:0]   dec;
    logic [CNT_W-1:0] add_amt;

    assign add_amt = add_valid_i ? add_amt_i : '0;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CNT_W-1:0] inc;

        // Decide this channel's increment and whether a drain applies to it.
        always_comb begin
            inc    = (add_valid_i && (add_ch_i == CH_W'(c))) ? add_amt_i : '0;
            dec[c] = drain_valid_i && (drain_ch_i == CH_W'(c)) && (cnt_q[c] != '0);
        end

        // Track the entries this channel holds.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[c] <= '0;
            end else begin
                cnt_q[c] <= cnt_q[c] + inc - CNT_W'(dec[c]);
            end
        end

        assign alloc_o[c*CNT_W +: CNT_W] = cnt_q[c];
    end

    // Track free pool entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_o <= CNT_W'(POOL_DEPTH);
        end else begin
            free_o <= free_o - add_amt + CNT_W'(|dec);
        end
    end

endmodule

// File: rtl/fpool_sched.sv
// Buffer pool channel scheduler top. Classifies each channel as eligible or
// pool-short, lets the queue pick a winner, books the burst in the ledger
// and registers the grant.
// Assumes: burst_i and limit_i are stable while a channel is requesting.
module fpool_sched #(
    parameter int NCH        = 4,
    parameter int POOL_DEPTH = 256,
    localparam int CNT_W = fpool_pkg::cnt_bits(POOL_DEPTH),
    localparam int CH_W  = fpool_pkg::id_bits(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       req_i,
    input  logic [NCH*CNT_W-1:0] burst_i,
    input  logic [CNT_W-1:0]     limit_i,
    input  logic                 drain_valid_i,
    input  logic [CH_W-1:0]      drain_ch_i,
    output logic                 grant_valid_o,
    output logic [CH_W-1:0]      grant_ch_o,
    output logic [NCH*CNT_W-1:0] alloc_o,
    output logic [CNT_W-1:0]     free_o
);

    logic [NCH-1:0]   elig;
    logic [NCH-1:0]   short;
    logic             pick_valid;
    logic [CH_W-1:0]  pick_ch;
    logic [CNT_W-1:0] pick_burst;

    for (genvar c = 0; c < NCH; c++) begin : g_cls
        logic [CNT_W-1:0] b;
        logic [CNT_W-1:0] a;
        logic             live;
        logic             below;

        // Classify the channel against the limit and the free pool.
        always_comb begin
            b        = burst_i[c*CNT_W +: CNT_W];
            a        = alloc_o[c*CNT_W +: CNT_W];
            live     = req_i[c] && (b != '0);
            below    = a < limit_i;
            elig[c]  = live && below && (free_o >= b);
            short[c] = live && below && (free_o < b);
        end
    end

    assign pick_burst = burst_i[pick_ch*CNT_W +: CNT_W];

    fpool_queue #(.NCH(NCH)) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .elig_i       (elig),
        .short_i      (short),
        .pick_valid_o (pick_valid),
        .pick_ch_o    (pick_ch)
    );

    fpool_ledger #(.NCH(NCH), .POOL_DEPTH(POOL_DEPTH)) u_ledger (
        .clk           (clk),
        .rst_n         (rst_n),
        .add_valid_i   (pick_valid),
        .add_ch_i      (pick_ch),
        .add_amt_i     (pick_burst),
        .drain_valid_i (drain_valid_i),
        .drain_ch_i    (drain_ch_i),
        .alloc_o       (alloc_o),
        .free_o        (free_o)
    );

    // Register the grant decision alongside the ledger update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid_o <= 1'b0;
            grant_ch_o    <= '0;
        end else begin
            grant_valid_o <= pick_valid;
            grant_ch_o    <= pick_valid ? pick_ch : grant_ch_o;
        end
    end

endmodule

// File: rtl/fpool_sched_chk.sv
// Property checker for the buffer pool scheduler, bound to every instance.
// Keeps one-cycle copies of the inputs and outputs to relate each grant to
// the state it was decided on.
module fpool_sched_chk #(
    parameter int NCH        = 4,
    parameter int POOL_DEPTH = 256,
    localparam int CNT_W = fpool_pkg::cnt_bits(POOL_DEPTH),
    localparam int CH_W  = fpool_pkg::id_bits(NCH),
    localparam int SUM_W = CNT_W + CH_W + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       req_i,
    input logic [NCH*CNT_W-1:0] burst_i,
    input logic [CNT_W-1:0]     limit_i,
    input logic                 drain_valid_i,
    input logic [CH_W-1:0]      drain_ch_i,
    input logic                 grant_valid_o,
    input logic [CH_W-1:0]      grant_ch_o,
    input logic [NCH*CNT_W-1:0] alloc_o,
    input logic [CNT_W-1:0]     free_o
);

    logic                 seen;
    logic [NCH-1:0]       prv_req;
    logic [NCH*CNT_W-1:0] prv_burst;
    logic [NCH*CNT_W-1:0] prv_alloc;
    logic [CNT_W-1:0]     prv_limit;
    logic [CNT_W-1:0]     prv_free;
    logic                 prv_dv;
    logic [CH_W-1:0]      prv_dch;
    logic [SUM_W-1:0]     total;
    logic [CNT_W-1:0]     g_burst;
    logic [CNT_W-1:0]     g_alloc;
    logic                 prv_drain_ok;

    // Mark the cycles that have a full previous cycle behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // Keep last cycle's view of the block.
    always_ff @(posedge clk) begin
        prv_req   <= req_i;
        prv_burst <= burst_i;
        prv_alloc <= alloc_o;
        prv_limit <= limit_i;
        prv_free  <= free_o;
        prv_dv    <= drain_valid_i;
        prv_dch   <= drain_ch_i;
    end

    // Derive totals and the granted channel's previous figures.
    always_comb begin
        total = SUM_W'(free_o);
        for (int c = 0; c < NCH; c++) begin
            total = total + SUM_W'(alloc_o[c*CNT_W +: CNT_W]);
        end
        g_burst      = prv_burst[grant_ch_o*CNT_W +: CNT_W];
        g_alloc      = prv_alloc[grant_ch_o*CNT_W +: CNT_W];
        prv_drain_ok = prv_dv && (prv_alloc[prv_dch*CNT_W +: CNT_W] != '0);
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!grant_valid_o && (free_o == CNT_W'(POOL_DEPTH)) && (alloc_o == '0)));

    p_conserve_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (total == SUM_W'(POOL_DEPTH)));

    p_grant_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && grant_valid_o) |-> (prv_req[grant_ch_o] && (g_burst != '0) && (prv_free >= g_burst)));

    p_grant_free_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && grant_valid_o) |-> (free_o == prv_free - g_burst + CNT_W'(prv_drain_ok)));

    p_below_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && grant_valid_o) |-> (g_alloc < prv_limit));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !grant_valid_o && !prv_dv) |-> ((alloc_o == prv_alloc) && (free_o == prv_free)));

    p_grant_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (32'(grant_ch_o) < NCH));

endmodule

bind fpool_sched fpool_sched_chk #(.NCH(NCH), .POOL_DEPTH(POOL_DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .burst_i       (burst_i),
    .limit_i       (limit_i),
    .drain_valid_i (drain_valid_i),
    .drain_ch_i    (drain_ch_i),
    .grant_valid_o (grant_valid_o),
    .grant_ch_o    (grant_ch_o),
    .alloc_o       (alloc_o),
    .free_o        (free_o)
);

// File: tb/fpool_sched_tb.sv
// Directed bench for the buffer pool scheduler: 4 channels, 16-entry pool.
module fpool_sched_tb;

    localparam int NCH   = 4;
    localparam int POOL  = 16;
    localparam int CNT_W = 5;
    localparam int CH_W  = 2;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NCH-1:0]       req_i;
    logic [NCH*CNT_W-1:0] burst_i;
    logic [CNT_W-1:0]     limit_i;
    logic                 drain_valid_i;
    logic [CH_W-1:0]      drain_ch_i;
    logic                 grant_valid_o;
    logic [CH_W-1:0]      grant_ch_o;
    logic [NCH*CNT_W-1:0] alloc_o;
    logic [CNT_W-1:0]     free_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fpool_sched #(.NCH(NCH), .POOL_DEPTH(POOL)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .burst_i       (burst_i),
        .limit_i       (limit_i),
        .drain_valid_i (drain_valid_i),
        .drain_ch_i    (drain_ch_i),
        .grant_valid_o (grant_valid_o),
        .grant_ch_o    (grant_ch_o),
        .alloc_o       (alloc_o),
        .free_o        (free_o)
    );

    function automatic int cnt(input int c);
        return int'(alloc_o[c*CNT_W +: CNT_W]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_grant(input string tag, input int exp_ch);
        chk({tag, " grant_valid"}, int'(grant_valid_o), 1);
        chk({tag, " grant_ch"}, int'(grant_ch_o), exp_ch);
    endtask

    task automatic set_burst(input int b0, input int b1, input int b2, input int b3);
        burst_i = {CNT_W'(b3), CNT_W'(b2), CNT_W'(b1), CNT_W'(b0)};
    endtask

    // One cycle of stimulus; returns at the next falling edge with results visible.
    task automatic cyc(input logic [NCH-1:0] r, input logic dv, input int dch);
        req_i         = r;
        drain_valid_i = dv;
        drain_ch_i    = CH_W'(dch);
        @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        req_i = '0;
        drain_valid_i = 1'b0;
        drain_ch_i = '0;
        set_burst(0, 0, 0, 0);
        limit_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset values.
    task automatic t_reset;
        do_reset();
        chk("R1 grant_valid", int'(grant_valid_o), 0);
        chk("R1 free", int'(free_o), POOL);
        for (int c = 0; c < NCH; c++) chk("R1 alloc", cnt(c), 0);
    endtask

    // R2, R3: round robin among channels that all fit.
    task automatic t_round_robin;
        do_reset();
        limit_i = 5'd8;
        set_burst(2, 2, 2, 2);
        cyc(4'b1111, 0, 0); chk_grant("R3 rr first", 0);
        chk("R2 alloc0", cnt(0), 2);
        chk("R2 free", int'(free_o), 14);
        cyc(4'b1111, 0, 0); chk_grant("R3 rr second", 1);
        cyc(4'b1111, 0, 0); chk_grant("R3 rr third", 2);
        cyc(4'b1111, 0, 0); chk_grant("R3 rr fourth", 3);
        cyc(4'b1111, 0, 0); chk_grant("R3 rr wrap", 0);
        chk("R2 alloc0 twice", cnt(0), 4);
        chk("R2 free after five", int'(free_o), 6);
        cyc(4'b0000, 0, 0);
        chk("R5 idle grant_valid", int'(grant_valid_o), 0);
    endtask

    // R6: limit overshoot and limit block.
    task automatic t_limit;
        do_reset();
        limit_i = 5'd4;
        set_burst(3, 0, 0, 0);
        cyc(4'b0001, 0, 0); chk_grant("R6 first", 0);
        chk("R6 alloc0", cnt(0), 3);
        cyc(4'b0001, 0, 0); chk_grant("R6 overshoot", 0);
        chk("R6 alloc0 limit+burst-1", cnt(0), 6);
        cyc(4'b0001, 0, 0);
        chk("R6 at limit no grant", int'(grant_valid_o), 0);
        chk("R6 alloc0 held", cnt(0), 6);
        chk("R9 free", int'(free_o), 10);
    endtask

    // R4: pool-short channel ahead of the winner goes to the tail.
    task automatic t_requeue;
        do_reset();
        limit_i = 5'd16;
        set_burst(6, 2, 2, 12);
        cyc(4'b1000, 0, 0); chk_grant("R2 big burst", 3);
        chk("R2 free", int'(free_o), 4);
        cyc(4'b0111, 0, 0); chk_grant("R4 skip short", 1);
        chk("R4 alloc0 untouched", cnt(0), 0);
        chk("R4 free", int'(free_o), 2);
        for (int i = 0; i < 4; i++) cyc(4'b0000, 1, 3);
        chk("R7 alloc3 drained", cnt(3), 8);
        chk("R7 free drained", int'(free_o), 6);
        cyc(4'b0111, 0, 0); chk_grant("R4 requeued behind", 2);
        chk("R4 free", int'(free_o), 4);
        cyc(4'b0111, 0, 0); chk_grant("R4 short again", 1);
        chk("R4 alloc1", cnt(1), 4);
    endtask

    // R5: no eligible channel keeps the queue order.
    task automatic t_no_grant;
        do_reset();
        limit_i = 5'd16;
        set_burst(4, 4, 0, 14);
        cyc(4'b1000, 0, 0); chk_grant("R5 fill", 3);
        cyc(4'b0011, 0, 0);
        chk("R5 no grant", int'(grant_valid_o), 0);
        chk("R5 alloc0", cnt(0), 0);
        chk("R5 alloc1", cnt(1), 0);
        chk("R5 free", int'(free_o), 2);
        cyc(4'b0000, 1, 3);
        cyc(4'b0000, 1, 3);
        chk("R7 free", int'(free_o), 4);
        cyc(4'b0011, 0, 0); chk_grant("R5 order kept", 0);
    endtask

    // R7, R8, R6: grant and drain together, ignored drain, limit block with another winner.
    task automatic t_same_cycle;
        do_reset();
        limit_i = 5'd16;
        set_burst(4, 2, 0, 0);
        cyc(4'b0001, 0, 0); chk_grant("R8 setup", 0);
        chk("R8 alloc0", cnt(0), 4);
        cyc(4'b0001, 1, 0); chk_grant("R8 grant with drain", 0);
        chk("R8 alloc0 burst-1", cnt(0), 7);
        chk("R8 free", int'(free_o), 9);
        cyc(4'b0000, 1, 2);
        chk("R7 empty drain alloc2", cnt(2), 0);
        chk("R7 empty drain free", int'(free_o), 9);
        limit_i = 5'd7;
        cyc(4'b0001, 0, 0);
        chk("R6 at limit", int'(grant_valid_o), 0);
        chk("R6 alloc0 held", cnt(0), 7);
        cyc(4'b0011, 0, 0); chk_grant("R6 other wins", 1);
        chk("R9 free", int'(free_o), 7);
        cyc(4'b0000, 1, 0);
        chk("R7 drain alloc0", cnt(0), 6);
        chk("R7 drain free", int'(free_o), 8);
    endtask

    initial begin
        rst_n = 1'b0;
        req_i = '0;
        burst_i = '0;
        limit_i = '0;
        drain_valid_i = 1'b0;
        drain_ch_i = '0;
        t_reset();
        t_round_robin();
        t_limit();
        t_requeue();
        t_no_grant();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule